// File: doc/BRIEF.md
# Scaled Voltage Decimal Display

This block converts a held 8-bit analog-to-digital converter code into a three-digit voltage reading of the form d.dd on seven-segment outputs. The code is doubled, so the result is in hundredths of a volt. A code of 255 reads 5.10 and a code of 0 reads 0.00.

The doubled value is split into hundreds, tens and units decimal digits. Each digit is encoded into an active-high segment pattern. A decimal point is lit after the hundreds digit.

The outputs are registered. They load only on a clock edge where the valid strobe is sampled high, and they hold their value between strobes. Multiplexing the digits onto a shared display and any analog scaling sit outside the block.

Top module: `voltage_readout`

## Requirements
- R1: On a rising clock edge with `rst` high, all three segment outputs become 7'h00 and `dp_o` becomes 3'b000.
- R2: After an update from code C, the digits shown are the hundreds, tens and units of 2*C. The hundreds digit is on `seg_hund_o`, the tens on `seg_tens_o` and the units on `seg_unit_o`.
- R3: Segment bit 0 is segment a and bit 6 is segment g, active high. The digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R4: Leading zeros are not blanked. Code 0 shows 0.00 (3F,3F,3F) and code 255 shows 5.10 (6D,06,3F).
- R5: The units digit is always even and the hundreds digit never exceeds 5.
- R6: After any update, `dp_o` is 3'b100. Bit 2 is the decimal point of the hundreds digit, and the other two bits stay 0.
- R7: The outputs change on the rising edge where `code_valid_i` is sampled high, so the new reading is visible one clock after the strobe.
- R8: While `code_valid_i` is low, changes on `code_i` have no effect and the outputs hold their previous value.
- R9: When `rst` and `code_valid_i` are high on the same edge, reset wins and the outputs clear as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 8 | Held converter code |
| code_valid_i | input | 1 | Strobe that loads `code_i` into the display |
| seg_hund_o | output | 7 | Hundreds digit segments a..g (bit 0 = a) |
| seg_tens_o | output | 7 | Tens digit segments a..g |
| seg_unit_o | output | 7 | Units digit segments a..g |
| dp_o | output | 3 | Decimal point enables; bit 2 = hundreds, bit 1 = tens, bit 0 = units |

## Verification
Two events can fall in the same cycle: a reset and a valid strobe. The bench provokes this by raising both on one edge, carrying a code that would otherwise light every digit. It then judges that the segments and the decimal point come out cleared rather than showing the reading. A second pairing, a strobe on several consecutive edges with a different code each time, is judged by checking that only the code sampled at the last edge is displayed. A full sweep of all 256 codes checks each reading against twice the code split by integer division.

// File: rtl/volt_readout_pkg.sv
package volt_readout_pkg;
  parameter int CODE_W = 8;
  parameter int SCALE_SHIFT = 1;
  parameter int DIGITS = 3;
  parameter int SEG_W = 7;
  parameter int DP_DIGIT = DIGITS - 1;

  localparam int VAL_W = CODE_W + SCALE_SHIFT;
  localparam int BCD_W = 4 * DIGITS;

  typedef logic [3:0] bcd_digit_t;
  typedef logic [SEG_W-1:0] seg_pat_t;
endpackage

// File: rtl/vd_scale.sv
module vd_scale #(
  parameter int IN_W = 8,
  parameter int SHIFT = 1
) (
  input  logic [IN_W-1:0]       raw_i,
  output logic [IN_W+SHIFT-1:0] scaled_o
);
  // Multiplication by 2**SHIFT: zeros fill the low bits.
  assign scaled_o = {raw_i, {SHIFT{1'b0}}};
endmodule

// File: rtl/vd_bin2bcd.sv
module vd_bin2bcd #(
  parameter int BIN_W = 9,
  parameter int NDIG = 3
) (
  input  logic [BIN_W-1:0]  bin_i,
  output logic [4*NDIG-1:0] bcd_o
);
  localparam int ACC_W = BIN_W + 4 * NDIG;

  logic [ACC_W-1:0] acc;

  // Shift-and-add-3: before each shift, any digit at 5 or more gets 3 added.
  always_comb begin
    acc = '0;
    acc[BIN_W-1:0] = bin_i;
    for (int s = 0; s < BIN_W; s++) begin
      for (int d = 0; d < NDIG; d++) begin
        if (acc[BIN_W+4*d +: 4] >= 4'd5)
          acc[BIN_W+4*d +: 4] = acc[BIN_W+4*d +: 4] + 4'd3;
      end
      acc = acc << 1;
    end
    bcd_o = acc[BIN_W +: 4*NDIG];
  end
endmodule

// File: rtl/vd_seg_enc.sv
module vd_seg_enc
  import volt_readout_pkg::*;
(
  input  bcd_digit_t digit_i,
  output seg_pat_t   seg_o
);
  // Active high, bit 0 = a ... bit 6 = g. Codes above 9 give a blank digit.
  always_comb begin
    case (digit_i)
      4'd0:    seg_o = 7'h3F;
      4'd1:    seg_o = 7'h06;
      4'd2:    seg_o = 7'h5B;
      4'd3:    seg_o = 7'h4F;
      4'd4:    seg_o = 7'h66;
      4'd5:    seg_o = 7'h6D;
      4'd6:    seg_o = 7'h7D;
      4'd7:    seg_o = 7'h07;
      4'd8:    seg_o = 7'h7F;
      4'd9:    seg_o = 7'h6F;
      default: seg_o = 7'h00;
    endcase
  end
endmodule

// File: rtl/voltage_readout.sv
module voltage_readout
  import volt_readout_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [CODE_W-1:0] code_i,
  input  logic             code_valid_i,
  output logic [SEG_W-1:0] seg_hund_o,
  output logic [SEG_W-1:0] seg_tens_o,
  output logic [SEG_W-1:0] seg_unit_o,
  output logic [DIGITS-1:0] dp_o
);
  logic [VAL_W-1:0]                scaled;
  logic [BCD_W-1:0]                bcd;
  logic [DIGITS-1:0][SEG_W-1:0]    seg_next;
  logic [DIGITS-1:0][SEG_W-1:0]    seg_q;
  logic [DIGITS-1:0]               dp_q;

  vd_scale #(.IN_W(CODE_W), .SHIFT(SCALE_SHIFT)) u_scale (
    .raw_i    (code_i),
    .scaled_o (scaled)
  );

  vd_bin2bcd #(.BIN_W(VAL_W), .NDIG(DIGITS)) u_bcd (
    .bin_i (scaled),
    .bcd_o (bcd)
  );

  // R5: the doubled value is even and at most 510.
  assert_units_even_R5: assert property (@(posedge clk) disable iff (rst)
    code_valid_i |-> (bcd[0] == 1'b0));
  assert_hund_max_R5: assert property (@(posedge clk) disable iff (rst)
    code_valid_i |-> (bcd[4*(DIGITS-1) +: 4] <= 4'd5));

  genvar g;
  generate
    for (g = 0; g < DIGITS; g++) begin : g_digit
      vd_seg_enc u_enc (
        .digit_i (bcd[4*g +: 4]),
        .seg_o   (seg_next[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= '0;
      dp_q  <= '0;
    end else if (code_valid_i) begin
      seg_q <= seg_next;
      dp_q  <= DIGITS'(1) << DP_DIGIT;
    end
  end

  assign seg_unit_o = seg_q[0];
  assign seg_tens_o = seg_q[1];
  assign seg_hund_o = seg_q[DIGITS-1];
  assign dp_o       = dp_q;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (seg_q == '0 && dp_q == '0));
  assert_dp_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dp_q));
  assert_update_dp_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(code_valid_i)) |-> (dp_q[DP_DIGIT] == 1'b1));
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(code_valid_i)) |-> ($stable(seg_q) && $stable(dp_q)));
endmodule

// File: tb/voltage_readout_test.sv
module voltage_readout_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] code_i = '0;
  logic       code_valid_i = 1'b0;
  logic [6:0] seg_hund_o, seg_tens_o, seg_unit_o;
  logic [2:0] dp_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  voltage_readout uut (
    .clk          (clk),
    .rst          (rst),
    .code_i       (code_i),
    .code_valid_i (code_valid_i),
    .seg_hund_o   (seg_hund_o),
    .seg_tens_o   (seg_tens_o),
    .seg_unit_o   (seg_unit_o),
    .dp_o         (dp_o)
  );

  // {code, hundreds, tens, units}
  localparam logic [19:0] VEC [8] = '{
    {8'd0,   4'd0, 4'd0, 4'd0},
    {8'd1,   4'd0, 4'd0, 4'd2},
    {8'd49,  4'd0, 4'd9, 4'd8},
    {8'd50,  4'd1, 4'd0, 4'd0},
    {8'd127, 4'd2, 4'd5, 4'd4},
    {8'd128, 4'd2, 4'd5, 4'd6},
    {8'd200, 4'd4, 4'd0, 4'd0},
    {8'd255, 4'd5, 4'd1, 4'd0}
  };

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: pat = 7'h3F; 1: pat = 7'h06; 2: pat = 7'h5B; 3: pat = 7'h4F;
      4: pat = 7'h66; 5: pat = 7'h6D; 6: pat = 7'h7D; 7: pat = 7'h07;
      8: pat = 7'h7F; 9: pat = 7'h6F; default: pat = 7'h00;
    endcase
  endfunction

  task automatic expect_out(input string req, input logic [6:0] h, input logic [6:0] t,
                            input logic [6:0] u, input logic [2:0] dp);
    n_cmp++;
    if (seg_hund_o !== h || seg_tens_o !== t || seg_unit_o !== u || dp_o !== dp) begin
      n_bad++;
      $display("FAIL %s: got %h %h %h dp=%b, expected %h %h %h dp=%b",
               req, seg_hund_o, seg_tens_o, seg_unit_o, dp_o, h, t, u, dp);
    end
  endtask

  task automatic strobe(input logic [7:0] c);
    @(negedge clk);
    code_i = c;
    code_valid_i = 1'b1;
    @(negedge clk);
    code_valid_i = 1'b0;
  endtask

  task automatic expect_digits(input string req, input int h, input int t, input int u);
    expect_out(req, pat(h), pat(t), pat(u), 3'b100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_out("R1 reset", 7'h00, 7'h00, 7'h00, 3'b000);
    rst = 1'b0;

    // R2 R3 R6 table walk
    foreach (VEC[i]) begin
      strobe(VEC[i][19:12]);
      expect_digits("R2/R3/R6 table", int'(VEC[i][11:8]), int'(VEC[i][7:4]), int'(VEC[i][3:0]));
    end

    // R4: no blanking at zero, full scale reads 5.10
    strobe(8'd0);
    expect_out("R4 zero", 7'h3F, 7'h3F, 7'h3F, 3'b100);
    strobe(8'd255);
    expect_out("R4 full", 7'h6D, 7'h06, 7'h3F, 3'b100);

    // R2 R5: full sweep against integer division
    for (int c = 0; c < 256; c++) begin
      int v;
      v = 2 * c;
      strobe(c[7:0]);
      expect_digits("R2/R5 sweep", v / 100, (v / 10) % 10, v % 10);
    end

    // R7: visible exactly one clock after the strobe
    @(negedge clk);
    code_i = 8'd123;
    code_valid_i = 1'b1;
    expect_digits("R7 before edge", 5, 1, 0);
    @(negedge clk);
    code_valid_i = 1'b0;
    expect_digits("R7 after edge", 2, 4, 6);

    // R8: code changes without a strobe are ignored
    code_i = 8'd77;
    repeat (4) @(negedge clk);
    expect_digits("R8 hold", 2, 4, 6);

    // back-to-back strobes: last sampled code wins
    @(negedge clk);
    code_valid_i = 1'b1;
    code_i = 8'd10;
    @(negedge clk);
    code_i = 8'd11;
    @(negedge clk);
    code_i = 8'd12;
    @(negedge clk);
    code_valid_i = 1'b0;
    expect_digits("R7 consecutive", 0, 2, 4);

    // R9: reset and strobe on the same edge
    @(negedge clk);
    rst = 1'b1;
    code_i = 8'd222;
    code_valid_i = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    code_valid_i = 1'b0;
    expect_out("R9 reset wins", 7'h00, 7'h00, 7'h00, 3'b000);

    strobe(8'd250);
    expect_digits("R6 after reset", 5, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule